// File: doc/BRIEF.md
# PWM generator with two-part duty and boundary-latched compare

This block produces one pulse-width-modulated output from a free-running period timer. The duty value is 10 bits wide and is written by a host in two pieces through separate write strobes. A coarse write sets the upper 8 bits. A fine write sets the lower 2 bits. The host may issue the two writes in different cycles, and in either order. The output never sees a mixed value: both pieces wait in staging registers. They are copied together into a shadow compare register only on the clock where a period ends.

The period timer counts whole ticks from zero up to a programmable limit. Each tick lasts four clocks, and those four clocks form the 2-bit sub-count that gives the duty its fine resolution. The output goes high at the start of each period and stays high while the fine position (tick × 4 + sub-count) is below the shadow duty. A postscaler counts period ends and pulses an interrupt strobe once every programmable number of them. The pulse needs no acknowledgement. The current tick count is always visible for polling. When the enable input is low, the timer, the sub-count and the postscaler are held at zero and the output is held low.

Top module: `pwm_split_duty`

## Requirements
- R1: While reset is asserted, pwm_o, irq_o and tmr_o are all 0, and the staging and shadow duty registers clear to 0.
- R2: While enabled, the tick count runs 0, 1, …, per_i and then wraps to 0. Each tick value lasts 4 clocks, so one period is 4 × (per_i + 1) clocks.
- R3: The fine position is tmr × 4 + sub-count (sub-count 0..3 within a tick). pwm_o is 1 exactly when enabled and the fine position is below the shadow duty.
- R4: A shadow duty of 0 keeps pwm_o low for the whole period. A shadow duty of at least 4 × (per_i + 1) keeps it high for the whole period.
- R5: A clock with wr_hi_i = 1 stores wdata_i[7:0] as duty bits 9:2. A clock with wr_lo_i = 1 stores wdata_i[1:0] as duty bits 1:0. Each write leaves the other part unchanged.
- R6: While enabled, the shadow duty takes the staged value only on the last clock of a period (tick = per_i and sub-count = 3). A write in the middle of a period has no effect on pwm_o until the next period starts.
- R7: irq_o is a single-clock pulse in the first clock of a period. It fires after every (post_i + 1)-th completed period and needs no clearing.
- R8: With en_i = 0, pwm_o is 0, the tick count, sub-count and postscaler are reset, and the shadow follows the staged duty. The first period after en_i rises therefore uses the latest written value.
- R9: tmr_o always shows the current tick count (0 while disabled).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| en_i | input | 1 | Run enable; low holds the counters and the output low |
| per_i | input | 8 | Last tick value of a period |
| post_i | input | 4 | Postscaler setting; interrupt every post_i + 1 periods |
| wr_hi_i | input | 1 | Write strobe for duty bits 9:2 |
| wr_lo_i | input | 1 | Write strobe for duty bits 1:0 |
| wdata_i | input | 8 | Write data for either duty part |
| pwm_o | output | 1 | PWM output |
| irq_o | output | 1 | One-clock interrupt pulse |
| tmr_o | output | 8 | Live tick count |

## Verification
The bench sweeps every duty value from 0 up to past the full-period value at a small period setting. A compare that is off by one on the fine position would show up as one extra or one missing high clock per period. It writes the two duty parts at scattered points inside a period. A design that let either part reach the compare early would change the pulse width mid-period or produce one period with a mixed value. It steps through tiny periods and every small postscaler setting, including a period of one tick and a postscaler of one. A postscaler that miscounted or restarted on the wrong edge would space the interrupts wrongly. It also drops the enable mid-period and rewrites the duty while disabled. A design that kept a stale shadow or left the counters running would start the next run at the wrong phase or width.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  // Position within a period at sub-tick resolution.
  function automatic logic [31:0] fine_pos(input logic [31:0] tick,
                                           input logic [31:0] sub,
                                           input int          sub_w);
    return (tick << sub_w) | sub;
  endfunction

  // Output level for a fine position against a duty.
  function automatic logic level_at(input logic [31:0] pos,
                                    input logic [31:0] duty);
    return pos < duty;
  endfunction

  // Postscaler next count: wraps once it reaches the programmed last value.
  function automatic logic [31:0] ps_next(input logic [31:0] cnt,
                                          input logic [31:0] last);
    return (cnt >= last) ? 32'd0 : cnt + 32'd1;
  endfunction

endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int TMR_W = 8,
  parameter int SUB_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [TMR_W-1:0] per_i,
  output logic [TMR_W-1:0] tick_o,
  output logic [SUB_W-1:0] sub_o,
  output logic             wrap_o
);
  logic [TMR_W-1:0] tick_q;
  logic [SUB_W-1:0] sub_q;
  logic             sub_last;
  logic             tick_last;

  assign sub_last  = &sub_q;
  assign tick_last = (tick_q >= per_i);
  assign wrap_o    = en_i & sub_last & tick_last;

  always_ff @(posedge clk_i) begin
    if (!rst_ni || !en_i) begin
      tick_q <= '0;
      sub_q  <= '0;
    end else if (sub_last) begin
      sub_q  <= '0;
      tick_q <= tick_last ? '0 : tick_q + 1'b1;
    end else begin
      sub_q  <= sub_q + 1'b1;
    end
  end

  assign tick_o = tick_q;
  assign sub_o  = sub_q;
endmodule

// File: rtl/pwm_duty_regs.sv
module pwm_duty_regs #(
  parameter int TMR_W = 8,
  parameter int SUB_W = 2,
  localparam int DUTY_W = TMR_W + SUB_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_hi_i,
  input  logic              wr_lo_i,
  input  logic [TMR_W-1:0]  wdata_i,
  input  logic              load_i,
  output logic [DUTY_W-1:0] shadow_o
);
  logic [TMR_W-1:0]  hi_q;
  logic [SUB_W-1:0]  lo_q;
  logic [DUTY_W-1:0] shadow_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      if (wr_hi_i) hi_q <= wdata_i;
      if (wr_lo_i) lo_q <= wdata_i[SUB_W-1:0];
    end
  end

  // Both parts move together so the compare never sees a mixed value.
  always_ff @(posedge clk_i) begin
    if (!rst_ni)     shadow_q <= '0;
    else if (load_i) shadow_q <= {hi_q, lo_q};
  end

  assign shadow_o = shadow_q;
endmodule

// File: rtl/pwm_postscale.sv
module pwm_postscale #(
  parameter int PS_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            tick_i,
  input  logic [PS_W-1:0] last_i,
  output logic            irq_o
);
  logic [PS_W-1:0] cnt_q;
  logic            irq_q;
  logic            hit;

  assign hit = tick_i && (cnt_q >= last_i);

  always_ff @(posedge clk_i) begin
    if (!rst_ni || !en_i) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= hit;
      if (tick_i)
        cnt_q <= PS_W'(pwm_pkg::ps_next(32'(cnt_q), 32'(last_i)));
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/pwm_split_duty.sv
module pwm_split_duty #(
  parameter int TMR_W = 8,
  parameter int SUB_W = 2,
  parameter int PS_W  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [TMR_W-1:0] per_i,
  input  logic [PS_W-1:0]  post_i,
  input  logic             wr_hi_i,
  input  logic             wr_lo_i,
  input  logic [TMR_W-1:0] wdata_i,
  output logic             pwm_o,
  output logic             irq_o,
  output logic [TMR_W-1:0] tmr_o
);
  localparam int DUTY_W = TMR_W + SUB_W;

  logic [TMR_W-1:0]  tick_w;
  logic [SUB_W-1:0]  sub_w;
  logic              wrap_w;
  logic              load_w;
  logic [DUTY_W-1:0] shadow_w;
  logic [DUTY_W-1:0] fine_w;

  pwm_timebase #(.TMR_W(TMR_W), .SUB_W(SUB_W)) u_tb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .per_i  (per_i),
    .tick_o (tick_w),
    .sub_o  (sub_w),
    .wrap_o (wrap_w)
  );

  // Shadow follows the staged value while idle, else only at a period end.
  assign load_w = wrap_w | ~en_i;

  pwm_duty_regs #(.TMR_W(TMR_W), .SUB_W(SUB_W)) u_duty (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_hi_i  (wr_hi_i),
    .wr_lo_i  (wr_lo_i),
    .wdata_i  (wdata_i),
    .load_i   (load_w),
    .shadow_o (shadow_w)
  );

  pwm_postscale #(.PS_W(PS_W)) u_ps (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .tick_i (wrap_w),
    .last_i (post_i),
    .irq_o  (irq_o)
  );

  assign fine_w = DUTY_W'(pwm_pkg::fine_pos(32'(tick_w), 32'(sub_w), SUB_W));
  assign pwm_o  = en_i & pwm_pkg::level_at(32'(fine_w), 32'(shadow_w));
  assign tmr_o  = tick_w;
endmodule

// File: rtl/pwm_split_duty_chk.sv
module pwm_split_duty_chk #(
  parameter int TMR_W = 8,
  parameter int SUB_W = 2,
  localparam int DUTY_W = TMR_W + SUB_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              pwm_o,
  input logic              irq_o,
  input logic [TMR_W-1:0]  tmr_o,
  input logic [SUB_W-1:0]  sub_w,
  input logic              wrap_w,
  input logic [DUTY_W-1:0] shadow_w
);
  p_tick_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && sub_w != '1) |=> (!en_i || tmr_o == $past(tmr_o)));

  p_start_high_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tmr_o == '0 && sub_w == '0 && shadow_w != '0) |-> pwm_o);

  p_zero_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shadow_w == '0) |-> !pwm_o);

  p_shadow_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !wrap_w) |=> $stable(shadow_w));

  p_irq_after_wrap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(wrap_w));

  p_irq_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  p_off_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !pwm_o);
endmodule

bind pwm_split_duty pwm_split_duty_chk #(.TMR_W(TMR_W), .SUB_W(SUB_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .en_i     (en_i),
  .pwm_o    (pwm_o),
  .irq_o    (irq_o),
  .tmr_o    (tmr_o),
  .sub_w    (sub_w),
  .wrap_w   (wrap_w),
  .shadow_w (shadow_w)
);

// File: tb/pwm_split_duty_tb.sv
module pwm_split_duty_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni, en_i, wr_hi_i, wr_lo_i;
  logic [7:0] per_i, wdata_i;
  logic [3:0] post_i;
  logic       pwm_o, irq_o;
  logic [7:0] tmr_o;

  always #2 clk_i = ~clk_i;

  pwm_split_duty u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .per_i(per_i),
    .post_i(post_i), .wr_hi_i(wr_hi_i), .wr_lo_i(wr_lo_i),
    .wdata_i(wdata_i), .pwm_o(pwm_o), .irq_o(irq_o), .tmr_o(tmr_o)
  );

  int    n_vec = 0, n_bad = 0, cyc = 0;
  int    k = 0, sh = 0, hi_m = 0, lo_m = 0, ps_m = 0, irq_m = 0;
  int    last_irq = -1, hi_acc = 0, acc_ok = 0;
  string tag_pwm = "R3";
  bit    done = 0;

  task automatic chk(string req, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // One clock: reference model on the pre-edge inputs, then sample at negedge.
  task automatic step();
    int p4;
    @(posedge clk_i);
    cyc++;
    p4 = 4 * (int'(per_i) + 1);
    if (!rst_ni) begin
      k = 0; sh = 0; hi_m = 0; lo_m = 0; ps_m = 0; irq_m = 0;
    end else begin
      if (!en_i) begin
        k = 0; sh = hi_m * 4 + lo_m; ps_m = 0; irq_m = 0;
      end else begin
        irq_m = (k == p4 - 1 && ps_m >= int'(post_i)) ? 1 : 0;
        if (k == p4 - 1) begin
          k = 0; sh = hi_m * 4 + lo_m;
          ps_m = (ps_m >= int'(post_i)) ? 0 : ps_m + 1;
        end else k++;
      end
      if (wr_hi_i) hi_m = int'(wdata_i);
      if (wr_lo_i) lo_m = int'(wdata_i) & 3;
    end
    @(negedge clk_i);
    if (rst_ni) begin
      chk(tag_pwm, int'(pwm_o), (en_i && k < sh) ? 1 : 0);
      chk("R9", int'(tmr_o), k / 4);
      chk("R7", int'(irq_o), irq_m);
      if (irq_o && post_i == 4'd0) begin
        if (last_irq >= 0) chk("R2", cyc - last_irq, p4);
        last_irq = cyc;
      end
      if (!en_i) acc_ok = 0;
      else begin
        if (k == 0) begin acc_ok = 1; hi_acc = 0; end
        hi_acc += int'(pwm_o);
        if (k == p4 - 1 && acc_ok == 1)
          chk("R4", hi_acc, (sh < p4) ? sh : p4);
      end
    end
  endtask

  task automatic wr_hi(int v);
    wr_hi_i = 1'b1; wdata_i = 8'(v); step(); wr_hi_i = 1'b0;
  endtask

  task automatic wr_lo(int v);
    wr_lo_i = 1'b1; wdata_i = 8'(v); step(); wr_lo_i = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    rst_ni = 1'b0; en_i = 1'b0; wr_hi_i = 1'b0; wr_lo_i = 1'b0;
    per_i = 8'd4; post_i = 4'd2; wdata_i = 8'd0;
    repeat (3) step();
    // R1: outputs during reset
    chk("R1", int'(pwm_o), 0);
    chk("R1", int'(irq_o), 0);
    chk("R1", int'(tmr_o), 0);
    rst_ni = 1'b1;
    step();
    chk("R1", int'(pwm_o), 0);

    // R3/R5/R6: duty sweep past full scale, parts written mid-period
    en_i = 1'b1;
    for (int d = 0; d <= 22; d++) begin
      tag_pwm = "R6";
      repeat (d % 7) step();
      wr_hi(d >> 2);
      repeat (3) step();
      tag_pwm = "R5";
      wr_lo(d & 3);
      while (k != 0) step();
      tag_pwm = "R3";
      repeat (40) step();
    end

    // R5: only the coarse part rewritten, fine part kept
    tag_pwm = "R5";
    wr_lo(3);
    wr_hi(1);
    repeat (45) step();
    wr_hi(3);
    repeat (45) step();

    // R8: disable mid-period, rewrite while idle, restart uses new value
    repeat (7) step();
    tag_pwm = "R8";
    en_i = 1'b0;
    repeat (3) step();
    wr_hi(2);
    wr_lo(1);
    step();
    en_i = 1'b1;
    repeat (30) step();

    // R2/R7: small periods against every small postscaler setting
    for (int p = 0; p <= 5; p++) begin
      for (int q = 0; q <= 3; q++) begin
        tag_pwm = "R8";
        en_i = 1'b0;
        step();
        per_i = 8'(p); post_i = 4'(q); last_irq = -1;
        wr_hi(p); wr_lo(p & 3);
        step();
        en_i = 1'b1;
        tag_pwm = "R3";
        repeat ((q + 1) * (p + 1) * 4 * 3 + 2) step();
      end
    end

    // R4: zero duty and over-full duty on a mid-size period
    en_i = 1'b0; step();
    per_i = 8'd2; post_i = 4'd1;
    tag_pwm = "R4";
    wr_hi(0); wr_lo(0); step();
    en_i = 1'b1;
    repeat (30) step();
    wr_hi(3); wr_lo(0);
    repeat (30) step();
    wr_hi(10);
    repeat (30) step();

    finish_run();
  end
endmodule